// File: doc/BRIEF.md
# Masked Status Condition Evaluator

This block turns the per-descriptor qualifier fields of a DMA command, together with the channel's low device-status nibble, into the three yes/no decisions a descriptor engine needs when it completes a command. These decisions are whether to raise the interrupt, whether to take the branch target instead of the sequential next descriptor, and whether to hold the channel waiting. Each decision has its own 32-bit select register. The select register packs a 4-bit mask and a 4-bit compare value. The raw condition is a masked equality between the status nibble and the compare value. A 2-bit qualifier then forces the decision low, passes the condition, inverts it, or forces it high.

The parameter `SHARED` picks the implementation. With `SHARED=0`, three evaluator slices work in parallel and a request is answered one cycle after it is accepted. With `SHARED=1`, one evaluator is time-shared under a small state machine. It uses state ST_IDLE to accept a request and capture the inputs. It then steps through ST_WAIT, ST_IRQ and ST_BRANCH, evaluating one decision in each. The transitions are: ST_IDLE→ST_WAIT on `start`; ST_WAIT→ST_IRQ, ST_IRQ→ST_BRANCH and ST_BRANCH→ST_IDLE unconditionally. All three decisions are published together when ST_BRANCH is left. The caller acts on the decisions; this block only produces them.

Top module: `cond_eval_top`

## Requirements
- R1: In each select register, bits 19:16 are the mask and bits 3:0 are the compare value. All other select bits have no effect on any decision.
- R2: The condition is true when (status AND mask) equals (value AND mask). A zero mask therefore always gives a true condition.
- R3: Qualifier code 00 (never) gives a decision of 0 whatever the condition.
- R4: Qualifier code 11 (always) gives a decision of 1 whatever the condition.
- R5: Qualifier code 01 (if-set) gives the condition unchanged.
- R6: Qualifier code 10 (if-clear) gives the inverted condition.
- R7: The interrupt decision `irq_req` uses command bits 5:4 with `irq_sel`. The branch decision `branch_take` (1 = branch target, 0 = sequential next) uses bits 3:2 with `branch_sel`. The wait decision `wait_hold` uses bits 1:0 with `wait_sel`.
- R8: `result_valid` is a one-cycle pulse. With SHARED=0, a `start` is accepted every cycle and the pulse follows in the next cycle. With SHARED=1, a `start` in ST_IDLE is accepted, `busy` is high for the following three cycles, and the pulse comes in the cycle after that. A `start` raised while `busy` is ignored.
- R9: With SHARED=1, the inputs are captured in the cycle the request is accepted. Later changes to the command, status or select inputs do not alter that result.
- R10: After reset, `result_valid`, `busy` and all three decisions are 0.
- R11: The three decisions change only in a cycle where `result_valid` is high, and they hold their values until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Evaluation request |
| cmd_ctl | input | 6 | Qualifier fields: interrupt 5:4, branch 3:2, wait 1:0 |
| dev_status | input | 4 | Low device-status bits of the channel |
| irq_sel | input | 32 | Interrupt select: mask 19:16, value 3:0 |
| branch_sel | input | 32 | Branch select: mask 19:16, value 3:0 |
| wait_sel | input | 32 | Wait select: mask 19:16, value 3:0 |
| busy | output | 1 | Sequencer is evaluating (always 0 when SHARED=0) |
| result_valid | output | 1 | One-cycle pulse: new decisions published |
| irq_req | output | 1 | Interrupt decision |
| branch_take | output | 1 | Branch decision |
| wait_hold | output | 1 | Wait decision |

## Verification
The bench builds two instances with the same inputs. `dut` has the default SHARED=1, and `dut_par` has SHARED=0; field positions and widths stay at their defaults. Driving both from one vector table checks that the time-shared sequencer and the replicated slices give the same decisions. The two instances have different latencies, so the bench also checks each latency. The SHARED=1 build exposes the behaviours that only a multi-cycle evaluation has: a request raised mid-evaluation is dropped, inputs that change after acceptance are not seen, and the outputs hold steady while the partial results build up internally.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    // Qualifier encoding of each 2-bit decision field
    typedef enum logic [1:0] {
        QUAL_NEVER  = 2'b00,
        QUAL_IFSET  = 2'b01,
        QUAL_IFCLR  = 2'b10,
        QUAL_ALWAYS = 2'b11
    } qual_e;

    // Sequencer states for the time-shared variant
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_IRQ    = 2'd2,
        ST_BRANCH = 2'd3
    } seq_e;

    localparam int COND_W = 4;
    localparam int QUAL_W = 2;

endpackage

// File: rtl/cond_match.sv
module cond_match
    import cond_eval_pkg::*;
#(
    parameter int SEL_W    = 32,
    parameter int MASK_LSB = 16,
    parameter int VAL_LSB  = 0
) (
    input  logic [COND_W-1:0] dev_status,
    input  logic [SEL_W-1:0]  sel,
    output logic              match
);

    logic [COND_W-1:0] fld_mask;
    logic [COND_W-1:0] fld_val;
    logic              unused_sel_bits;

    assign fld_mask        = sel[MASK_LSB +: COND_W];
    assign fld_val         = sel[VAL_LSB  +: COND_W];
    assign unused_sel_bits = ^sel;

    always_comb begin
        match = ((dev_status & fld_mask) == (fld_val & fld_mask));
    end

endmodule

// File: rtl/cond_qual.sv
module cond_qual
    import cond_eval_pkg::*;
(
    input  qual_e qual,
    input  logic  match,
    output logic  decide
);

    always_comb begin
        unique case (qual)
            QUAL_NEVER:  decide = 1'b0;
            QUAL_IFSET:  decide = match;
            QUAL_IFCLR:  decide = ~match;
            QUAL_ALWAYS: decide = 1'b1;
        endcase
    end

endmodule

// File: rtl/cond_eval_top.sv
module cond_eval_top
    import cond_eval_pkg::*;
#(
    parameter bit SHARED   = 1'b1,
    parameter int SEL_W    = 32,
    parameter int CMD_W    = 6,
    parameter int MASK_LSB = 16,
    parameter int VAL_LSB  = 0,
    parameter int IRQ_LSB  = 4,
    parameter int BR_LSB   = 2,
    parameter int WAIT_LSB = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd_ctl,
    input  logic [COND_W-1:0] dev_status,
    input  logic [SEL_W-1:0]  irq_sel,
    input  logic [SEL_W-1:0]  branch_sel,
    input  logic [SEL_W-1:0]  wait_sel,
    output logic              busy,
    output logic              result_valid,
    output logic              irq_req,
    output logic              branch_take,
    output logic              wait_hold
);

    localparam int N_DEC = 3;

    generate
        if (SHARED) begin : g_shared
            seq_e              state, state_nx;
            logic [CMD_W-1:0]  cap_cmd;
            logic [COND_W-1:0] cap_stat;
            logic [SEL_W-1:0]  cap_isel, cap_bsel, cap_wsel;
            logic [QUAL_W-1:0] cur_qual;
            logic [SEL_W-1:0]  cur_sel;
            logic              cur_match, cur_dec;
            logic              part_wait, part_irq;
            logic              accept;

            assign accept = start && (state == ST_IDLE);

            // state register
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) state <= ST_IDLE;
                else        state <= state_nx;
            end

            // next state
            always_comb begin
                state_nx = state;
                unique case (state)
                    ST_IDLE:   if (start) state_nx = ST_WAIT;
                    ST_WAIT:   state_nx = ST_IRQ;
                    ST_IRQ:    state_nx = ST_BRANCH;
                    ST_BRANCH: state_nx = ST_IDLE;
                endcase
            end

            // operand steering per state
            always_comb begin
                unique case (state)
                    ST_WAIT: begin
                        cur_qual = cap_cmd[WAIT_LSB +: QUAL_W];
                        cur_sel  = cap_wsel;
                    end
                    ST_IRQ: begin
                        cur_qual = cap_cmd[IRQ_LSB +: QUAL_W];
                        cur_sel  = cap_isel;
                    end
                    ST_IDLE, ST_BRANCH: begin
                        cur_qual = cap_cmd[BR_LSB +: QUAL_W];
                        cur_sel  = cap_bsel;
                    end
                endcase
            end

            assign busy = (state != ST_IDLE);

            cond_match #(
                .SEL_W(SEL_W), .MASK_LSB(MASK_LSB), .VAL_LSB(VAL_LSB)
            ) u_match (
                .dev_status(cap_stat),
                .sel       (cur_sel),
                .match     (cur_match)
            );

            cond_qual u_qual (
                .qual  (qual_e'(cur_qual)),
                .match (cur_match),
                .decide(cur_dec)
            );

            // capture, partial results and publication
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cap_cmd      <= '0;
                    cap_stat     <= '0;
                    cap_isel     <= '0;
                    cap_bsel     <= '0;
                    cap_wsel     <= '0;
                    part_wait    <= 1'b0;
                    part_irq     <= 1'b0;
                    result_valid <= 1'b0;
                    irq_req      <= 1'b0;
                    branch_take  <= 1'b0;
                    wait_hold    <= 1'b0;
                end else begin
                    result_valid <= 1'b0;
                    if (accept) begin
                        cap_cmd  <= cmd_ctl;
                        cap_stat <= dev_status;
                        cap_isel <= irq_sel;
                        cap_bsel <= branch_sel;
                        cap_wsel <= wait_sel;
                    end
                    unique case (state)
                        ST_WAIT: part_wait <= cur_dec;
                        ST_IRQ:  part_irq  <= cur_dec;
                        ST_BRANCH: begin
                            wait_hold    <= part_wait;
                            irq_req      <= part_irq;
                            branch_take  <= cur_dec;
                            result_valid <= 1'b1;
                        end
                        ST_IDLE: ;
                    endcase
                end
            end
        end else begin : g_parallel
            logic [SEL_W-1:0]  slot_sel [N_DEC];
            logic [QUAL_W-1:0] slot_q   [N_DEC];
            logic [N_DEC-1:0]  slot_dec;

            // slot 0 = wait, 1 = interrupt, 2 = branch
            assign slot_sel[0] = wait_sel;
            assign slot_sel[1] = irq_sel;
            assign slot_sel[2] = branch_sel;
            assign slot_q[0]   = cmd_ctl[WAIT_LSB +: QUAL_W];
            assign slot_q[1]   = cmd_ctl[IRQ_LSB  +: QUAL_W];
            assign slot_q[2]   = cmd_ctl[BR_LSB   +: QUAL_W];

            for (genvar g = 0; g < N_DEC; g++) begin : g_slot
                logic slot_match;

                cond_match #(
                    .SEL_W(SEL_W), .MASK_LSB(MASK_LSB), .VAL_LSB(VAL_LSB)
                ) u_match (
                    .dev_status(dev_status),
                    .sel       (slot_sel[g]),
                    .match     (slot_match)
                );

                cond_qual u_qual (
                    .qual  (qual_e'(slot_q[g])),
                    .match (slot_match),
                    .decide(slot_dec[g])
                );
            end

            assign busy = 1'b0;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    result_valid <= 1'b0;
                    irq_req      <= 1'b0;
                    branch_take  <= 1'b0;
                    wait_hold    <= 1'b0;
                end else begin
                    result_valid <= start;
                    if (start) begin
                        wait_hold   <= slot_dec[0];
                        irq_req     <= slot_dec[1];
                        branch_take <= slot_dec[2];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk #(
    parameter bit SHARED  = 1'b1,
    parameter int CMD_W   = 6,
    parameter int IRQ_LSB = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CMD_W-1:0] cmd_ctl,
    input logic             busy,
    input logic             result_valid,
    input logic             irq_req,
    input logic             branch_take,
    input logic             wait_hold
);

    // R11: decisions move only together with the valid pulse
    a_r11_hold_between_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable({irq_req, branch_take, wait_hold}));

    generate
        if (SHARED) begin : g_seq_chk
            // R8: an accepted request makes the sequencer busy
            a_r8_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
                (start && !busy) |=> busy);
            // R8: the valid pulse lasts exactly one cycle
            a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
                result_valid |=> !result_valid);
            // R8: no result is published while evaluation is in progress
            a_r8_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
                busy |-> !result_valid);
            // R8: leaving the busy phase publishes a result
            a_r8_pulse_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(busy) |-> result_valid);
        end else begin : g_par_chk
            // R8: one-cycle answer in the replicated build
            a_r8_next_cycle_valid: assert property (@(posedge clk) disable iff (!rst_n)
                start |=> result_valid);
            a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
                !start |=> !result_valid);
            // R3: never-qualifier on the interrupt field
            a_r3_never_irq: assert property (@(posedge clk) disable iff (!rst_n)
                (start && cmd_ctl[IRQ_LSB +: 2] == 2'b00) |=> !irq_req);
            // R4: always-qualifier on the interrupt field
            a_r4_always_irq: assert property (@(posedge clk) disable iff (!rst_n)
                (start && cmd_ctl[IRQ_LSB +: 2] == 2'b11) |=> irq_req);
        end
    endgenerate

endmodule

bind cond_eval_top cond_eval_chk #(
    .SHARED (SHARED),
    .CMD_W  (CMD_W),
    .IRQ_LSB(IRQ_LSB)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cmd_ctl     (cmd_ctl),
    .busy        (busy),
    .result_valid(result_valid),
    .irq_req     (irq_req),
    .branch_take (branch_take),
    .wait_hold   (wait_hold)
);

// File: tb/tb_cond_eval_top.sv
module tb_cond_eval_top;

    typedef struct packed {
        logic [5:0]  cmd;
        logic [3:0]  st;
        logic [31:0] isel;
        logic [31:0] bsel;
        logic [31:0] wsel;
        logic [2:0]  exp;   // {irq, branch, wait}
    } vec_t;

    localparam int NV = 8;
    // Qualifier codes: 00 never, 01 if-set, 10 if-clear, 11 always.
    // Select: mask bits 19:16, value bits 3:0.
    localparam vec_t VECS [NV] = '{
        // R5, R2: all if-set; irq matches, branch misses, wait mask zero
        '{6'b01_01_01, 4'hA, 32'h000F_000A, 32'h000F_0005, 32'h0000_0003, 3'b101},
        // R6: all if-clear, same operands
        '{6'b10_10_10, 4'hA, 32'h000F_000A, 32'h000F_0005, 32'h0000_0003, 3'b010},
        // R3: all never
        '{6'b00_00_00, 4'hA, 32'h000F_000A, 32'h000F_0005, 32'h0000_0003, 3'b000},
        // R4: all always
        '{6'b11_11_11, 4'h5, 32'h000F_000A, 32'h000F_0005, 32'h000F_0000, 3'b111},
        // R1: junk outside the fields must be ignored
        '{6'b01_10_01, 4'h3, 32'hFFF3_FFF0, 32'hA5A1_5A53, 32'h0000_0000, 3'b001},
        // R7: a different qualifier per field
        '{6'b11_01_10, 4'h5, 32'h0000_0000, 32'h0005_0005, 32'h000C_0004, 3'b110},
        // R2: partial masks
        '{6'b01_01_01, 4'hF, 32'h0008_0000, 32'h0007_000F, 32'h0001_0001, 3'b011},
        // R7: interrupt if-clear, branch if-set, wait never
        '{6'b10_01_00, 4'h0, 32'h000F_0008, 32'h000F_0001, 32'h000F_0000, 3'b100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_ctl = '0;
    logic [3:0]  dev_status = '0;
    logic [31:0] irq_sel = '0, branch_sel = '0, wait_sel = '0;

    logic s_busy, s_valid, s_irq, s_br, s_wait;
    logic p_busy, p_valid, p_irq, p_br, p_wait;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    cond_eval_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_ctl(cmd_ctl),
        .dev_status(dev_status), .irq_sel(irq_sel), .branch_sel(branch_sel),
        .wait_sel(wait_sel), .busy(s_busy), .result_valid(s_valid),
        .irq_req(s_irq), .branch_take(s_br), .wait_hold(s_wait)
    );

    cond_eval_top #(.SHARED(1'b0)) dut_par (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_ctl(cmd_ctl),
        .dev_status(dev_status), .irq_sel(irq_sel), .branch_sel(branch_sel),
        .wait_sel(wait_sel), .busy(p_busy), .result_valid(p_valid),
        .irq_req(p_irq), .branch_take(p_br), .wait_hold(p_wait)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        cmd_ctl    = v.cmd;
        dev_status = v.st;
        irq_sel    = v.isel;
        branch_sel = v.bsel;
        wait_sel   = v.wsel;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10", "shared outputs", {s_busy, s_valid, s_irq, s_br, s_wait}, 0);
        check("R10", "parallel outputs", {p_busy, p_valid, p_irq, p_br, p_wait}, 0);

        // Table walk: R1..R7 on both builds, R8 latency on both
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R8", $sformatf("par valid v%0d", i), p_valid, 1);
            check("R7", $sformatf("par decisions v%0d", i), {p_irq, p_br, p_wait}, VECS[i].exp);
            check("R8", $sformatf("shared busy/valid v%0d", i), {s_busy, s_valid}, 2'b10);
            @(negedge clk);
            @(negedge clk);
            check("R8", $sformatf("shared still busy v%0d", i), {s_busy, s_valid}, 2'b10);
            @(negedge clk);
            check("R8", $sformatf("shared valid v%0d", i), {s_busy, s_valid}, 2'b01);
            check("R7", $sformatf("shared decisions v%0d", i), {s_irq, s_br, s_wait}, VECS[i].exp);
        end

        // R9: change every input right after acceptance
        @(negedge clk);
        drive(VECS[3]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cmd_ctl = 6'b00_00_00;
        dev_status = 4'h0;
        irq_sel = '0; branch_sel = '0; wait_sel = '0;
        check("R9", "parallel sees accept-cycle inputs", {p_irq, p_br, p_wait}, 3'b111);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check("R9", "shared valid", s_valid, 1);
        check("R9", "shared uses captured inputs", {s_irq, s_br, s_wait}, 3'b111);

        // R8: start while busy is ignored; R11: outputs hold
        @(negedge clk);
        drive(VECS[2]);
        start = 1'b1;
        @(negedge clk);
        drive(VECS[3]);          // second request arrives while busy
        check("R11", "shared holds during evaluation", {s_irq, s_br, s_wait}, 3'b111);
        @(negedge clk);
        start = 1'b0;
        check("R8", "parallel accepts back-to-back", {p_valid, p_irq, p_br, p_wait}, 4'b1111);
        @(negedge clk);
        check("R11", "shared holds before pulse", {s_valid, s_irq, s_br, s_wait}, 4'b0111);
        @(negedge clk);
        check("R8", "shared first request result", {s_valid, s_irq, s_br, s_wait}, 4'b1000);
        begin
            int extra = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (s_valid) extra++;
            end
            check("R8", "no pulse from ignored start", extra, 0);
        end
        check("R11", "shared holds after pulse", {s_busy, s_irq, s_br, s_wait}, 4'b0000);
        check("R11", "parallel holds after pulse", {p_valid, p_irq, p_br, p_wait}, 4'b0111);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule